// File: doc/BRIEF.md
# Atomic Memory Operation Execute Unit

This unit carries out one atomic read-modify-write on a single-port synchronous memory that sits outside it. A request names an operator, an operand size (byte, halfword, word or doubleword), a byte address, a source operand, a compare operand and a flag that marks the destination register as the zero register. The unit checks the request, claims the memory port with a lock signal, reads the 64-bit memory word that holds the operand, and forms the new value. It writes the new value back through byte-lane enables and then pulses a response carrying the old value, sign-extended to 64 bits.

Nine fetch-and-op operators and compare-and-swap share one datapath. Operand bits above the operation size are ignored. Minimum and maximum compare at the operation width. A compare-and-swap whose compare fails leaves memory untouched. Misaligned addresses and undefined operator codes raise an exception without touching memory. The acquire and release annotation bits are not interpreted: they travel with the request and come back on the response.

Top module: `amo_exec_unit`

## Requirements
- R1: Operator codes are swap=0, add=1, and=2, or=3 and xor=4. Each stores the operator applied to the old memory value (first operand) and the source operand, and returns the old value.
- R2: Operator codes are signed min=5, signed max=6, unsigned min=7 and unsigned max=8. Each compares at the operation width (byte, halfword, word or doubleword), not at 64 bits, and stores the selected value.
- R3: Size codes are byte=0, halfword=1, word=2 and doubleword=3. The memory word address is the byte address shifted right by 3. The lane offset is address bits [2:0], and mem_be bit i enables byte i. A sub-doubleword write changes only its own lanes, and source operand bits above the size are ignored.
- R4: rsp_rd_data is the old operand value, sign-extended from the operation size to 64 bits.
- R5: Compare-and-swap (code 9) writes the source operand only when the old value equals the low size-bits of the compare operand. Otherwise no write strobe is issued. It always returns the old value.
- R6: A request whose address is not a multiple of the operand size gets a response with rsp_exc=1 and rsp_rd_we=0 one cycle after acceptance. It issues no memory enable and leaves memory unchanged.
- R7: Operator codes 10 to 15 are treated as in R6.
- R8: When req_rd_zero is 1, rsp_rd_we is 0 and memory is still updated. Otherwise a successful response has rsp_rd_we=1.
- R9: A request is accepted on a clock edge where req_valid and req_ready are both 1. req_ready is 1 only when the unit is idle. A legal request's one-cycle rsp_valid pulse appears four cycles after acceptance, with the memory read data arriving one cycle after a read enable.
- R10: mem_lock is 1 during every cycle with mem_en=1. It stays 1 without a gap from the read enable to the end of the write cycle, so it covers exactly three cycles per legal operation.
- R11: rsp_aq and rsp_rl return the req_aq and req_rl values of the request being answered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request can be accepted |
| req_op | input | 4 | Operator code |
| req_size | input | 2 | Operand size code |
| req_addr | input | ADDR_W | Byte address |
| req_rs2 | input | 64 | Source operand |
| req_cmp | input | 64 | Compare operand for compare-and-swap |
| req_rd_zero | input | 1 | Destination is the zero register |
| req_aq | input | 1 | Acquire annotation (sideband) |
| req_rl | input | 1 | Release annotation (sideband) |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rd_we | output | 1 | Register writeback requested |
| rsp_rd_data | output | 64 | Sign-extended old value |
| rsp_exc | output | 1 | Misaligned or undefined request |
| rsp_aq | output | 1 | Returned acquire annotation |
| rsp_rl | output | 1 | Returned release annotation |
| mem_lock | output | 1 | Memory port held by this unit |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Write (1) or read (0) |
| mem_addr | output | ADDR_W-3 | Memory word address |
| mem_be | output | 8 | Byte-lane write enables |
| mem_wdata | output | 64 | Write data |
| mem_rdata | input | 64 | Read data, one cycle after read enable |

## Verification
The embedded assertions check, on every cycle, the properties that depend only on control timing. Every memory enable falls inside the lock, and the lock does not drop between read and write. The response is a single-cycle pulse while the unit refuses new requests. An exception response never asks for a writeback, and every write strobe has at least one lane enabled. The arithmetic is shown only by the bench's directed scenarios, which hold a memory model and compare literal expected values. Those scenarios cover operator results, width-correct min/max, sign extension, untouched neighbouring lanes, ignored upper operand bits, compare-and-swap success and failure, and the absence of memory traffic after a misaligned or undefined request.

// File: rtl/amo_pkg.sv
package amo_pkg;
  localparam int DATA_W = 64;
  localparam int LANES  = DATA_W / 8;
  localparam int OFF_W  = $clog2(LANES);

  typedef enum logic [3:0] {
    OP_SWAP = 4'd0,
    OP_ADD  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_XOR  = 4'd4,
    OP_MIN  = 4'd5,
    OP_MAX  = 4'd6,
    OP_MINU = 4'd7,
    OP_MAXU = 4'd8,
    OP_CAS  = 4'd9
  } amo_op_e;

  typedef enum logic [1:0] {
    SZ_B = 2'd0,
    SZ_H = 2'd1,
    SZ_W = 2'd2,
    SZ_D = 2'd3
  } amo_size_e;

  function automatic logic op_defined(input logic [3:0] op);
    return op <= 4'(OP_CAS);
  endfunction

  function automatic logic addr_aligned(input logic [OFF_W-1:0] off,
                                        input logic [1:0] size);
    logic [OFF_W-1:0] low_mask;
    low_mask = OFF_W'((1 << size) - 1);
    return (off & low_mask) == '0;
  endfunction
endpackage

// File: rtl/amo_extract.sv
module amo_extract
  import amo_pkg::*;
(
  input  logic [DATA_W-1:0] word_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [1:0]        size_i,
  output logic [DATA_W-1:0] sext_o,
  output logic [DATA_W-1:0] zext_o
);
  logic [DATA_W-1:0] shifted;

  always_comb begin
    shifted = word_i >> {off_i, 3'b000};
    unique case (size_i)
      SZ_B: begin
        zext_o = {{(DATA_W-8){1'b0}}, shifted[7:0]};
        sext_o = {{(DATA_W-8){shifted[7]}}, shifted[7:0]};
      end
      SZ_H: begin
        zext_o = {{(DATA_W-16){1'b0}}, shifted[15:0]};
        sext_o = {{(DATA_W-16){shifted[15]}}, shifted[15:0]};
      end
      SZ_W: begin
        zext_o = {{(DATA_W-32){1'b0}}, shifted[31:0]};
        sext_o = {{(DATA_W-32){shifted[31]}}, shifted[31:0]};
      end
      default: begin
        zext_o = shifted;
        sext_o = shifted;
      end
    endcase
  end
endmodule

// File: rtl/amo_alu.sv
module amo_alu
  import amo_pkg::*;
(
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] old_s_i,
  input  logic [DATA_W-1:0] old_u_i,
  input  logic [DATA_W-1:0] src_s_i,
  input  logic [DATA_W-1:0] src_u_i,
  input  logic [DATA_W-1:0] cmp_u_i,
  output logic [DATA_W-1:0] new_o,
  output logic              wr_o
);
  logic lt_s, lt_u;

  assign lt_s = $signed(old_s_i) < $signed(src_s_i);
  assign lt_u = old_u_i < src_u_i;

  always_comb begin
    wr_o  = 1'b1;
    new_o = src_u_i;
    unique case (op_i)
      OP_SWAP: new_o = src_u_i;
      OP_ADD:  new_o = old_u_i + src_u_i;
      OP_AND:  new_o = old_u_i & src_u_i;
      OP_OR:   new_o = old_u_i | src_u_i;
      OP_XOR:  new_o = old_u_i ^ src_u_i;
      OP_MIN:  new_o = lt_s ? old_u_i : src_u_i;
      OP_MAX:  new_o = lt_s ? src_u_i : old_u_i;
      OP_MINU: new_o = lt_u ? old_u_i : src_u_i;
      OP_MAXU: new_o = lt_u ? src_u_i : old_u_i;
      OP_CAS: begin
        new_o = src_u_i;
        wr_o  = (old_u_i == cmp_u_i);
      end
      default: wr_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/amo_insert.sv
module amo_insert
  import amo_pkg::*;
(
  input  logic [DATA_W-1:0] val_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [1:0]        size_i,
  output logic [DATA_W-1:0] wdata_o,
  output logic [LANES-1:0]  be_o
);
  logic [LANES-1:0] base_mask;

  always_comb begin
    base_mask = LANES'((1 << (1 << size_i)) - 1);
    be_o      = base_mask << off_i;
    wdata_o   = val_i << {off_i, 3'b000};
  end
endmodule

// File: rtl/amo_exec_unit.sv
module amo_exec_unit
  import amo_pkg::*;
#(
  parameter int ADDR_W = 12,
  localparam int WA_W  = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [3:0]        req_op,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_rs2,
  input  logic [DATA_W-1:0] req_cmp,
  input  logic              req_rd_zero,
  input  logic              req_aq,
  input  logic              req_rl,
  output logic              rsp_valid,
  output logic              rsp_rd_we,
  output logic [DATA_W-1:0] rsp_rd_data,
  output logic              rsp_exc,
  output logic              rsp_aq,
  output logic              rsp_rl,
  output logic              mem_lock,
  output logic              mem_en,
  output logic              mem_we,
  output logic [WA_W-1:0]   mem_addr,
  output logic [LANES-1:0]  mem_be,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  typedef enum logic [2:0] {S_IDLE, S_READ, S_WAIT, S_WRITE, S_RESP} st_e;
  st_e state;

  logic [3:0]        op_q;
  logic [1:0]        size_q;
  logic [OFF_W-1:0]  off_q;
  logic [DATA_W-1:0] rs2_q, cmp_q, old_q;
  logic              rdz_q;

  logic [DATA_W-1:0] old_s, old_u, src_s, src_u, cmp_s, cmp_u;
  logic [DATA_W-1:0] new_val, wdata;
  logic [LANES-1:0]  be;
  logic              do_write, req_ok;

  assign req_ready = (state == S_IDLE);
  assign req_ok = op_defined(req_op) &&
                  addr_aligned(req_addr[OFF_W-1:0], req_size);

  amo_extract u_old (.word_i(mem_rdata), .off_i(off_q), .size_i(size_q),
                     .sext_o(old_s), .zext_o(old_u));
  amo_extract u_src (.word_i(rs2_q), .off_i('0), .size_i(size_q),
                     .sext_o(src_s), .zext_o(src_u));
  amo_extract u_cmp (.word_i(cmp_q), .off_i('0), .size_i(size_q),
                     .sext_o(cmp_s), .zext_o(cmp_u));

  amo_alu u_alu (.op_i(op_q), .old_s_i(old_s), .old_u_i(old_u),
                 .src_s_i(src_s), .src_u_i(src_u), .cmp_u_i(cmp_u),
                 .new_o(new_val), .wr_o(do_write));

  amo_insert u_ins (.val_i(new_val), .off_i(off_q), .size_i(size_q),
                    .wdata_o(wdata), .be_o(be));

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      op_q        <= '0;
      size_q      <= '0;
      off_q       <= '0;
      rs2_q       <= '0;
      cmp_q       <= '0;
      old_q       <= '0;
      rdz_q       <= 1'b0;
      rsp_valid   <= 1'b0;
      rsp_rd_we   <= 1'b0;
      rsp_rd_data <= '0;
      rsp_exc     <= 1'b0;
      rsp_aq      <= 1'b0;
      rsp_rl      <= 1'b0;
      mem_lock    <= 1'b0;
      mem_en      <= 1'b0;
      mem_we      <= 1'b0;
      mem_addr    <= '0;
      mem_be      <= '0;
      mem_wdata   <= '0;
    end else begin
      unique case (state)
        S_IDLE: begin
          if (req_valid) begin
            op_q   <= req_op;
            size_q <= req_size;
            off_q  <= req_addr[OFF_W-1:0];
            rs2_q  <= req_rs2;
            cmp_q  <= req_cmp;
            rdz_q  <= req_rd_zero;
            rsp_aq <= req_aq;
            rsp_rl <= req_rl;
            if (!req_ok) begin
              rsp_valid   <= 1'b1;
              rsp_exc     <= 1'b1;
              rsp_rd_we   <= 1'b0;
              rsp_rd_data <= '0;
              state       <= S_RESP;
            end else begin
              mem_lock <= 1'b1;
              mem_en   <= 1'b1;
              mem_we   <= 1'b0;
              mem_be   <= '0;
              mem_addr <= req_addr[ADDR_W-1:OFF_W];
              state    <= S_READ;
            end
          end
        end
        S_READ: begin
          mem_en <= 1'b0;
          state  <= S_WAIT;
        end
        S_WAIT: begin
          old_q     <= old_s;
          mem_en    <= do_write;
          mem_we    <= do_write;
          mem_be    <= be;
          mem_wdata <= wdata;
          state     <= S_WRITE;
        end
        S_WRITE: begin
          mem_en      <= 1'b0;
          mem_we      <= 1'b0;
          mem_be      <= '0;
          mem_lock    <= 1'b0;
          rsp_valid   <= 1'b1;
          rsp_exc     <= 1'b0;
          rsp_rd_we   <= !rdz_q;
          rsp_rd_data <= rdz_q ? '0 : old_q;
          state       <= S_RESP;
        end
        default: begin
          rsp_valid <= 1'b0;
          rsp_rd_we <= 1'b0;
          state     <= S_IDLE;
        end
      endcase
    end
  end

  // R10
  mem_in_lock_chk: assert property (@(posedge clk) disable iff (rst)
    mem_en |-> mem_lock);

  // R10
  lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_en && !mem_we) |=> mem_lock);

  // R9
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R9
  busy_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid || mem_lock) |-> !req_ready);

  // R6
  exc_no_wb_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_exc) |-> !rsp_rd_we);

  // R3
  write_lanes_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_en && mem_we) |-> (mem_be != '0));
endmodule

// File: tb/test_amo_exec_unit.sv
`timescale 1ns/1ps
module test_amo_exec_unit;
  localparam int ADDR_W = 12;
  localparam int WA_W   = ADDR_W - 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic              req_valid = 1'b0, req_ready;
  logic [3:0]        req_op = '0;
  logic [1:0]        req_size = '0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [63:0]       req_rs2 = '0, req_cmp = '0;
  logic              req_rd_zero = 1'b0, req_aq = 1'b0, req_rl = 1'b0;
  logic              rsp_valid, rsp_rd_we, rsp_exc, rsp_aq, rsp_rl;
  logic [63:0]       rsp_rd_data;
  logic              mem_lock, mem_en, mem_we;
  logic [WA_W-1:0]   mem_addr;
  logic [7:0]        mem_be;
  logic [63:0]       mem_wdata;
  logic [63:0]       mem_rdata = '0;

  amo_exec_unit #(.ADDR_W(ADDR_W)) i_amo_exec_unit (
    .clk, .rst, .req_valid, .req_ready, .req_op, .req_size, .req_addr,
    .req_rs2, .req_cmp, .req_rd_zero, .req_aq, .req_rl,
    .rsp_valid, .rsp_rd_we, .rsp_rd_data, .rsp_exc, .rsp_aq, .rsp_rl,
    .mem_lock, .mem_en, .mem_we, .mem_addr, .mem_be, .mem_wdata, .mem_rdata);

  logic [63:0] mem [0:(1<<WA_W)-1];
  int wr_cnt = 0, en_cnt = 0, lock_cnt = 0, ready_busy = 0;

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) begin
        for (int i = 0; i < 8; i++)
          if (mem_be[i]) mem[mem_addr][i*8 +: 8] <= mem_wdata[i*8 +: 8];
      end else begin
        mem_rdata <= mem[mem_addr];
      end
    end
    if (!rst) begin
      if (mem_en && mem_we) wr_cnt <= wr_cnt + 1;
      if (mem_en) en_cnt <= en_cnt + 1;
      if (mem_lock) lock_cnt <= lock_cnt + 1;
      if (mem_lock && req_ready) ready_busy <= ready_busy + 1;
    end
  end

  int n_chk = 0, n_bad = 0;
  logic [63:0] r_data;
  logic r_we, r_exc, r_aq, r_rl;
  int r_lat;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [3:0] op, input logic [1:0] sz,
                     input logic [ADDR_W-1:0] a, input logic [63:0] rs2,
                     input logic [63:0] cmp, input logic rdz,
                     input logic aq, input logic rl);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_size = sz; req_addr = a;
    req_rs2 = rs2; req_cmp = cmp; req_rd_zero = rdz; req_aq = aq; req_rl = rl;
    @(posedge clk);
    #0.5 req_valid = 1'b0;
    r_lat = 0;
    do begin
      @(negedge clk);
      r_lat++;
    end while (!rsp_valid && r_lat < 50);
    r_data = rsp_rd_data; r_we = rsp_rd_we; r_exc = rsp_exc;
    r_aq = rsp_aq; r_rl = rsp_rl;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R9 ready after reset", 64'(req_ready), 64'd1);
    chk("R9 no response after reset", 64'(rsp_valid), 64'd0);
    chk("R10 no lock after reset", 64'(mem_lock), 64'd0);
  endtask

  task automatic t_arith;
    int l0;
    mem[4] = 64'h0000_0001_FFFF_FFFF;
    l0 = lock_cnt;
    run(4'd1, 2'd3, 12'h020, 64'd1, 64'd0, 1'b0, 1'b0, 1'b0);
    chk("R1 add d old", r_data, 64'h0000_0001_FFFF_FFFF);
    chk("R1 add d mem", mem[4], 64'h0000_0002_0000_0000);
    chk("R9 latency", 64'(r_lat), 64'd4);
    chk("R10 lock cycles", 64'(lock_cnt - l0), 64'd3);
    chk("R8 rd we set", 64'(r_we), 64'd1);
    mem[4] = 64'h7FFF_FFFF_1234_5678;
    run(4'd1, 2'd2, 12'h024, 64'hDEAD_BEEF_0000_0001, 64'd0, 1'b0, 1'b0, 1'b0);
    chk("R4 add w old", r_data, 64'h0000_0000_7FFF_FFFF);
    chk("R3 add w mem lanes", mem[4], 64'h8000_0000_1234_5678);
    mem[8] = 64'h1122_3344_5566_7788;
    run(4'd0, 2'd3, 12'h040, 64'hCAFE, 64'd0, 1'b0, 1'b0, 1'b0);
    chk("R1 swap old", r_data, 64'h1122_3344_5566_7788);
    chk("R1 swap mem", mem[8], 64'hCAFE);
  endtask

  task automatic t_logic;
    mem[7] = 64'hF0F0_F0F0_0F0F_0F0F;
    run(4'd2, 2'd2, 12'h038, 64'h00FF_00FF, 64'd0, 1'b0, 1'b0, 1'b0);
    chk("R1 and old", r_data, 64'h0000_0000_0F0F_0F0F);
    run(4'd3, 2'd2, 12'h038, 64'hFF00_0000, 64'd0, 1'b0, 1'b0, 1'b0);
    chk("R1 or old", r_data, 64'h0000_0000_000F_000F);
    run(4'd4, 2'd2, 12'h038, 64'hFFFF_FFFF, 64'd0, 1'b0, 1'b0, 1'b0);
    chk("R4 xor old sext", r_data, 64'hFFFF_FFFF_FF0F_000F);
    chk("R1 xor mem", mem[7], 64'hF0F0_F0F0_00F0_FFF0);
  endtask

  task automatic t_minmax;
    mem[5] = 64'h0102_0304_0580_0607;
    run(4'd5, 2'd0, 12'h02A, 64'h7F, 64'd0, 1'b0, 1'b0, 1'b0);
    chk("R2 min byte signed keeps", mem[5], 64'h0102_0304_0580_0607);
    chk("R4 byte old sext", r_data, 64'hFFFF_FFFF_FFFF_FF80);
    run(4'd7, 2'd0, 12'h02A, 64'hFFFF_FF7F, 64'd0, 1'b0, 1'b0, 1'b0);
    chk("R2 minu byte", mem[5], 64'h0102_0304_057F_0607);
    mem[6] = 64'hAAAA_AAAA_AAAA_8000;
    run(4'd6, 2'd1, 12'h030, 64'hFFFF, 64'd0, 1'b0, 1'b0, 1'b0);
    chk("R2 max half signed", mem[6], 64'hAAAA_AAAA_AAAA_FFFF);
    chk("R4 half old sext", r_data, 64'hFFFF_FFFF_FFFF_8000);
    run(4'd8, 2'd1, 12'h030, 64'h0001, 64'd0, 1'b0, 1'b0, 1'b0);
    chk("R2 maxu half keeps", mem[6], 64'hAAAA_AAAA_AAAA_FFFF);
  endtask

  task automatic t_cas;
    int w0;
    mem[9] = 64'h5555_5555_8000_0001;
    w0 = wr_cnt;
    run(4'd9, 2'd2, 12'h048, 64'h42, 64'h1234_5678_8000_0001, 1'b0, 1'b0, 1'b0);
    chk("R5 cas hit old", r_data, 64'hFFFF_FFFF_8000_0001);
    chk("R5 cas hit mem", mem[9], 64'h5555_5555_0000_0042);
    chk("R5 cas hit write", 64'(wr_cnt - w0), 64'd1);
    w0 = wr_cnt;
    run(4'd9, 2'd2, 12'h048, 64'h77, 64'h43, 1'b0, 1'b0, 1'b0);
    chk("R5 cas miss old", r_data, 64'h42);
    chk("R5 cas miss mem", mem[9], 64'h5555_5555_0000_0042);
    chk("R5 cas miss no write", 64'(wr_cnt - w0), 64'd0);
  endtask

  task automatic t_zero_dest;
    mem[10] = 64'd10;
    run(4'd1, 2'd3, 12'h050, 64'd5, 64'd0, 1'b1, 1'b0, 1'b0);
    chk("R8 no rd we", 64'(r_we), 64'd0);
    chk("R8 mem updated", mem[10], 64'd15);
  endtask

  task automatic t_bad;
    int e0;
    mem[4] = 64'h0123_4567_89AB_CDEF;
    e0 = en_cnt;
    run(4'd1, 2'd2, 12'h022, 64'd1, 64'd0, 1'b0, 1'b0, 1'b0);
    chk("R6 misaligned w exc", 64'(r_exc), 64'd1);
    chk("R6 misaligned no rd we", 64'(r_we), 64'd0);
    chk("R6 exc latency", 64'(r_lat), 64'd1);
    run(4'd0, 2'd3, 12'h024, 64'd1, 64'd0, 1'b0, 1'b0, 1'b0);
    chk("R6 misaligned d exc", 64'(r_exc), 64'd1);
    run(4'd0, 2'd1, 12'h021, 64'd1, 64'd0, 1'b0, 1'b0, 1'b0);
    chk("R6 misaligned h exc", 64'(r_exc), 64'd1);
    run(4'd12, 2'd3, 12'h020, 64'd1, 64'd0, 1'b0, 1'b0, 1'b0);
    chk("R7 undefined op exc", 64'(r_exc), 64'd1);
    chk("R6 R7 no mem enable", 64'(en_cnt - e0), 64'd0);
    chk("R6 mem unchanged", mem[4], 64'h0123_4567_89AB_CDEF);
  endtask

  task automatic t_sideband;
    run(4'd1, 2'd3, 12'h058, 64'd0, 64'd0, 1'b0, 1'b1, 1'b0);
    chk("R11 aq echo", {r_aq, r_rl}, 64'b10);
    run(4'd1, 2'd3, 12'h058, 64'd0, 64'd0, 1'b0, 1'b0, 1'b1);
    chk("R11 rl echo", {r_aq, r_rl}, 64'b01);
    chk("R9 not ready while busy", 64'(ready_busy), 64'd0);
  endtask

  bit done = 1'b0;

  initial begin
    repeat (3) @(posedge clk);
    #0.5 rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_arith();
    t_logic();
    t_minmax();
    t_cas();
    t_zero_dest();
    t_bad();
    t_sideband();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule